// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block is a counter-based one-shot generator. Once software enables it, it sits waiting with its counter parked at all ones. A trigger, either a chosen edge on an external pin or a self-clearing software trigger bit, clears the counter to zero and starts it counting on every count-enable tick. The output turns active when the count reaches the start compare value. It stays active through the count that equals the end compare value, and returns to inactive on the next tick. The counter then rests at zero until the next trigger. A start value D and an end value E therefore give a delay of D ticks and an active width of E − D + 1 ticks.

Both compare values pass through shadow copies. The shadows follow the written values only while the timer is not running, so software may reprogram during a pulse without disturbing it. Two single-cycle strobes mark the counter arriving at the start value and at the end value. Triggers that arrive during a running cycle are dropped. Clearing the enable bit aborts the cycle at once.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset, pulse_out, irq_start and irq_end are all 0. The reset defaults are: timer disabled, active level high, rising-edge trigger, both compare values 0.
- R2: A write with wr_sel=0 sets the control fields: bit 0 enable, bit 1 software trigger (acts only in the cycle of the write and is not stored), bits 3:2 external edge mode (0 none, 1 rising, 2 falling, 3 both), bit 4 active level (1 = active high). wr_sel=1 writes the start compare and wr_sel=2 writes the end compare. A write with wr_sel=3 changes nothing.
- R3: While enabled and waiting without a trigger, the output stays inactive and no strobe fires.
- R4: An accepted trigger clears the count to 0 on that clock edge. The output goes active on the edge where the count reaches the start value D. With tick held high, that is D cycles after the trigger edge, or on the trigger edge itself when D is 0.
- R5: The output stays active for E − D + 1 ticks and goes inactive on the tick after the count equals E. The count then rests at 0. When E < D the output never goes active and the cycle still ends after count E.
- R6: irq_start is a one-cycle strobe on the edge where the count becomes D. irq_end is a one-cycle strobe on the edge where the count becomes E.
- R7: A trigger that arrives while a cycle is running is ignored.
- R8: ext_trig passes through a two-flip-flop synchronizer before edge detection, so an edge is acted on at the third rising clock edge after it. Only edges of the selected polarity count.
- R9: A compare value written while a cycle is running has no effect until the next trigger.
- R10: Clearing enable forces the output inactive on that edge and returns the counter to all ones. After re-enabling, a trigger starts a normal cycle from 0.
- R11: With the active level set to 0, the output idles high and is low during the active phase.
- R12: The count advances only on clock edges where tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 start compare, 2 end compare |
| wr_data | input | CNT_W | Write data |
| tick | input | 1 | Count enable |
| ext_trig | input | 1 | External trigger pin (asynchronous) |
| pulse_out | output | 1 | One-shot output, registered |
| irq_start | output | 1 | Strobe when the count reaches the start compare value |
| irq_end | output | 1 | Strobe when the count reaches the end compare value |

## Verification
The bench runs a behavioural model in parallel with the design and compares every cycle. It also measures delay and width directly for start value 0, end below start, and a tick that is high on alternate cycles. A design that counted a trigger during a running cycle would stretch the pulse. A design that used unbuffered compare values would cut short a pulse reprogrammed mid-flight, and that is checked too. Further checks cover each edge mode, including an edge of the wrong polarity and a synchronizer with the wrong depth, which would shift the delay. Disabling during the active phase must drop the output at once, and the next cycle must restart from zero instead of resuming.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_END   = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  localparam int CB_EN   = 0;
  localparam int CB_SW   = 1;
  localparam int CB_EDGE = 2;
  localparam int CB_LVL  = 4;
endpackage

// File: rtl/otp_trig_sync.sv
module otp_trig_sync
  import otp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  pin,
  input  edge_e mode,
  output logic  hit
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[LAST-1:0], pin};
  end

  logic cur, prv;
  assign cur = sh[LAST-1];
  assign prv = sh[LAST];

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = cur & ~prv;
      EDGE_FALL: hit = ~cur & prv;
      EDGE_BOTH: hit = cur ^ prv;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             run_q,
  output logic             en_nxt,
  output logic             lvl_nxt,
  output logic             sw_trig,
  output edge_e            edge_mode,
  output logic [CNT_W-1:0] cmp_start,
  output logic [CNT_W-1:0] cmp_end,
  output logic [CNT_W-1:0] buf_end
);
  logic             en_q, lvl_q;
  edge_e            edge_q;
  logic [CNT_W-1:0] r_start, r_end, b_start, b_end;
  logic             ctrl_wr;

  assign ctrl_wr   = wr_en && (sel_e'(wr_sel) == SEL_CTRL);
  assign en_nxt    = ctrl_wr ? wr_data[CB_EN]  : en_q;
  assign lvl_nxt   = ctrl_wr ? wr_data[CB_LVL] : lvl_q;
  assign sw_trig   = ctrl_wr && wr_data[CB_SW];
  assign edge_mode = edge_q;
  // While idle the values in force are the written ones; once running, the shadows.
  assign cmp_start = run_q ? b_start : r_start;
  assign cmp_end   = run_q ? b_end   : r_end;
  assign buf_end   = b_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      lvl_q   <= 1'b1;
      edge_q  <= EDGE_RISE;
      r_start <= '0;
      r_end   <= '0;
      b_start <= '0;
      b_end   <= '0;
    end else begin
      if (!run_q) begin
        b_start <= r_start;
        b_end   <= r_end;
      end
      if (wr_en) begin
        unique case (sel_e'(wr_sel))
          SEL_CTRL: begin
            en_q   <= wr_data[CB_EN];
            lvl_q  <= wr_data[CB_LVL];
            edge_q <= edge_e'(wr_data[CB_EDGE +: 2]);
          end
          SEL_START: r_start <= wr_data;
          SEL_END:   r_end   <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // R9: shadow copies hold still across any running cycle
  p_shadow_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    run_q |=> ($stable(b_start) && $stable(b_end)));
endmodule

// File: rtl/otp_core.sv
module otp_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             trig,
  input  logic             en_nxt,
  input  logic             lvl_nxt,
  input  logic [CNT_W-1:0] cmp_start,
  input  logic [CNT_W-1:0] cmp_end,
  input  logic [CNT_W-1:0] buf_end,
  output logic             run_q,
  output logic             pulse_out,
  output logic             irq_start,
  output logic             irq_end
);
  localparam logic [CNT_W-1:0] IDLE_CNT = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_n, adv, act_q, act_n, accept;

  assign accept = en_nxt && !run_q && trig;

  always_comb begin
    cnt_n = cnt_q;
    run_n = run_q;
    adv   = 1'b0;
    if (!en_nxt) begin
      cnt_n = IDLE_CNT;
      run_n = 1'b0;
    end else if (accept) begin
      cnt_n = '0;
      run_n = 1'b1;
      adv   = 1'b1;
    end else if (run_q && tick) begin
      if (cnt_q == cmp_end) begin
        cnt_n = '0;
        run_n = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
        adv   = 1'b1;
      end
    end
    act_n = run_n && (cnt_n >= cmp_start);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= IDLE_CNT;
      run_q     <= 1'b0;
      act_q     <= 1'b0;
      pulse_out <= 1'b0;
      irq_start <= 1'b0;
      irq_end   <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      run_q     <= run_n;
      act_q     <= act_n;
      pulse_out <= act_n ? lvl_nxt : ~lvl_nxt;
      irq_start <= adv && (cnt_n == cmp_start);
      irq_end   <= adv && (cnt_n == cmp_end);
    end
  end

  // R3: waiting without a trigger leaves the count parked
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (en_nxt && !run_q && !trig) |=> (!run_q && $stable(cnt_q)));

  // R5: active phase lies inside the running window bounded by the end shadow
  p_active_window_r5: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (run_q && cnt_q <= buf_end));

  // R6: strobes last one cycle
  p_start_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    irq_start |=> !irq_start);
  p_end_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    irq_end |=> !irq_end);

  // R7: a trigger in a running cycle does not restart the count
  p_no_retrigger_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q && trig && tick && en_nxt && cnt_q != cmp_end) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R10: disabling parks the counter and drops the active phase
  p_disable_park_r10: assert property (@(posedge clk) disable iff (rst)
    !en_nxt |=> (cnt_q == IDLE_CNT && !run_q && !act_q));
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
  import otp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  input  logic             ext_trig,
  output logic             pulse_out,
  output logic             irq_start,
  output logic             irq_end
);
  logic             en_nxt, lvl_nxt, sw_trig, ext_hit, run_q;
  edge_e            edge_mode;
  logic [CNT_W-1:0] cmp_start, cmp_end, buf_end;

  otp_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_trig), .mode(edge_mode), .hit(ext_hit)
  );

  otp_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .run_q(run_q), .en_nxt(en_nxt), .lvl_nxt(lvl_nxt), .sw_trig(sw_trig),
    .edge_mode(edge_mode), .cmp_start(cmp_start), .cmp_end(cmp_end),
    .buf_end(buf_end)
  );

  otp_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .trig(sw_trig | ext_hit),
    .en_nxt(en_nxt), .lvl_nxt(lvl_nxt), .cmp_start(cmp_start),
    .cmp_end(cmp_end), .buf_end(buf_end), .run_q(run_q),
    .pulse_out(pulse_out), .irq_start(irq_start), .irq_end(irq_end)
  );
endmodule

// File: tb/oneshot_pulse_timer_bench.sv
module oneshot_pulse_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        ext_trig = 1'b0;
  logic        tick_alt = 1'b0;
  logic        phase = 1'b0;
  logic        tick;
  logic        pulse_out, irq_start, irq_end;

  assign tick = tick_alt ? phase : 1'b1;

  always #2 clk = ~clk;

  oneshot_pulse_timer u_oneshot_pulse_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .ext_trig(ext_trig), .pulse_out(pulse_out),
    .irq_start(irq_start), .irq_end(irq_end)
  );

  int checks = 0, failures = 0, cyc = 0;
  int hi = 0, ns = 0, ne = 0, first_hi = -1, mark = 0;
  int lvl_sh = 1, edge_sh = 1;

  // behavioural reference state
  int m_en, m_lvl, m_edge, r_start, r_end, b_start, b_end, m_cnt;
  bit m_run, m_out, m_is, m_ie;
  bit s1, s2, s3;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (rst) begin
      m_en = 0; m_lvl = 1; m_edge = 1; r_start = 0; r_end = 0; b_start = 0; b_end = 0;
      m_cnt = 65535; m_run = 0; m_out = 0; m_is = 0; m_ie = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit ext_hit, is_ctrl, sw, en_n, lvl_n, run_n, adv, act;
      int e0, e1, cnt_n;
      ext_hit = (m_edge == 1 && s2 && !s3) || (m_edge == 2 && !s2 && s3) || (m_edge == 3 && s2 != s3);
      is_ctrl = wr_en && wr_sel == 2'd0;
      sw      = is_ctrl && wr_data[1];
      en_n    = is_ctrl ? wr_data[0] : (m_en != 0);
      lvl_n   = is_ctrl ? wr_data[4] : (m_lvl != 0);
      e0      = m_run ? b_end : r_end;
      e1      = m_run ? b_start : r_start;
      adv = 0; run_n = m_run; cnt_n = m_cnt;
      if (!en_n) begin
        cnt_n = 65535; run_n = 0;
      end else if (!m_run && (sw || ext_hit)) begin
        cnt_n = 0; run_n = 1; adv = 1;
      end else if (m_run && tick) begin
        if (m_cnt == e0) begin cnt_n = 0; run_n = 0; end
        else begin cnt_n = m_cnt + 1; adv = 1; end
      end
      act   = run_n && cnt_n >= e1;
      m_out = act ? lvl_n : !lvl_n;
      m_is  = adv && cnt_n == e1;
      m_ie  = adv && cnt_n == e0;
      if (!m_run) begin b_start = r_start; b_end = r_end; end
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin m_en = wr_data[0]; m_lvl = wr_data[4]; m_edge = wr_data[3:2]; end
          2'd1: r_start = wr_data;
          2'd2: r_end = wr_data;
          default: ;
        endcase
      end
      m_cnt = cnt_n; m_run = run_n;
      s3 = s2; s2 = s1; s1 = ext_trig;
    end
  end

  // per-cycle comparison and measurement, away from the active edge
  always @(negedge clk) begin
    phase <= ~phase;
    if (!rst) begin
      chk(pulse_out == m_out, "R4", "pulse_out vs model", pulse_out, m_out);
      chk(irq_start == m_is, "R6", "irq_start vs model", irq_start, m_is);
      chk(irq_end == m_ie, "R6", "irq_end vs model", irq_end, m_ie);
      if (pulse_out == lvl_sh[0]) begin
        hi++;
        if (first_hi < 0) first_hi = cyc;
      end
      if (irq_start) ns++;
      if (irq_end) ne++;
    end
  end

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[15:0];
    @(negedge clk);
    wr_en = 1'b0;
    mark = cyc;
  endtask

  task automatic ctrl(input int en, input int sw);
    wr(0, en | (sw << 1) | (edge_sh << 2) | (lvl_sh << 4));
  endtask

  task automatic clr();
    @(posedge clk);
    #1;
    hi = 0; ns = 0; ne = 0; first_hi = -1;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_set(input bit v);
    @(negedge clk);
    ext_trig = v;
    mark = cyc;
  endtask

  initial begin
    waitn(3);
    rst = 1'b0;
    @(negedge clk);
    chk(pulse_out == 1'b0, "R1", "pulse_out after reset", pulse_out, 0);
    chk(irq_start == 1'b0 && irq_end == 1'b0, "R1", "strobes after reset", irq_start + irq_end, 0);

    // R3: enabled, no trigger
    wr(1, 3); wr(2, 6); ctrl(1, 0);
    clr(); waitn(8);
    chk(hi == 0 && ns == 0 && ne == 0, "R3", "activity while waiting", hi + ns + ne, 0);

    // R4 R5 R6: software trigger, D=3 E=6
    clr(); ctrl(1, 1); waitn(15);
    chk(first_hi - mark == 3, "R4", "delay in ticks", first_hi - mark, 3);
    chk(hi == 4, "R5", "active width", hi, 4);
    chk(ns == 1 && ne == 1, "R6", "one strobe each", ns * 10 + ne, 11);

    // R7: retrigger during the active phase, D=2 E=9
    wr(1, 2); wr(2, 9);
    clr(); ctrl(1, 1); waitn(4); ctrl(1, 1); waitn(15);
    chk(hi == 8, "R7", "width with retrigger", hi, 8);
    chk(ne == 1, "R7", "end strobes with retrigger", ne, 1);

    // R2: select 3 writes nothing
    wr(3, 16'hFFFF);
    clr(); ctrl(1, 1); waitn(15);
    chk(hi == 8, "R2", "width after select-3 write", hi, 8);

    // R8: external edges, D=0 E=3
    wr(1, 0); wr(2, 3);
    clr(); ext_set(1'b1); waitn(12);
    chk(first_hi - mark == 3, "R8", "sync latency", first_hi - mark, 3);
    chk(hi == 4, "R8", "width from rising edge", hi, 4);
    clr(); ext_set(1'b0); waitn(12);
    chk(hi == 0, "R8", "falling edge ignored in rising mode", hi, 0);
    edge_sh = 2; ctrl(1, 0);
    clr(); ext_set(1'b1); waitn(12);
    chk(hi == 0, "R8", "rising edge ignored in falling mode", hi, 0);
    clr(); ext_set(1'b0); waitn(12);
    chk(hi == 4, "R8", "falling edge accepted", hi, 4);
    edge_sh = 3; ctrl(1, 0);
    clr(); ext_set(1'b1); waitn(12);
    chk(hi == 4, "R8", "either edge accepted", hi, 4);
    edge_sh = 0; ctrl(1, 0);

    // R9: reprogram during run
    wr(1, 2); wr(2, 5);
    clr(); ctrl(1, 1); waitn(2); wr(2, 20); waitn(12);
    chk(hi == 4, "R9", "width unchanged by mid-run write", hi, 4);
    clr(); ctrl(1, 1); waitn(30);
    chk(hi == 19, "R9", "new end value on next trigger", hi, 19);

    // R10: disable in the active phase
    clr(); ctrl(1, 1); waitn(5); ctrl(0, 0);
    chk(pulse_out == 1'b0, "R10", "output after disable", pulse_out, 0);
    ctrl(1, 0);
    clr(); ctrl(1, 1); waitn(30);
    chk(first_hi - mark == 2, "R10", "restart delay from zero", first_hi - mark, 2);
    chk(hi == 19, "R10", "restart width", hi, 19);

    // R11: active-low output
    lvl_sh = 0; ctrl(1, 0); waitn(1);
    chk(pulse_out == 1'b1, "R11", "idle level when active low", pulse_out, 1);
    wr(2, 5);
    clr(); ctrl(1, 1); waitn(12);
    chk(hi == 4, "R11", "low cycles", hi, 4);
    lvl_sh = 1; ctrl(1, 0);

    // R12: tick on alternate cycles
    tick_alt = 1'b1;
    clr(); ctrl(1, 1); waitn(30);
    chk(hi == 8, "R12", "width in cycles with half-rate tick", hi, 8);
    tick_alt = 1'b0;

    // R5: end below start
    wr(1, 7); wr(2, 3);
    clr(); ctrl(1, 1); waitn(15);
    chk(hi == 0 && ns == 0, "R5", "no active phase when end<start", hi + ns, 0);
    chk(ne == 1, "R5", "cycle still ends", ne, 1);

    // R4: start value 0
    wr(1, 0); wr(2, 0);
    clr(); ctrl(1, 1); waitn(6);
    chk(first_hi - mark == 0, "R4", "zero delay", first_hi - mark, 0);
    chk(hi == 1, "R4", "single-tick pulse", hi, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule